// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host end of a two-wire serial debug link. Each transaction is one register read or write on either the debug port or an access port. The caller presents a port select, a direction flag, a two-bit register address, write data and an idle-cycle count, then pulses `start`. The engine produces the debug clock. It shifts the eight-bit request out least significant bit first and releases the data line for turnaround. It collects the three-bit acknowledge and then moves a 32-bit word with its parity bit. At the end it returns line ownership to the host and pulses `done` with a status code.

The data line is split into `swdio_out`, `swdio_oe` and `swdio_in`, so the pad buffer sits outside the block. `HALF_DIV` sets how many system clock cycles each half of a debug clock period lasts, and it must be at least 2. A write to the debug-port target-select register gets no answer from the far end, so the engine ignores the acknowledge for that one request. After a successful access-port transfer, the engine runs the requested number of idle clock periods with the line held low. Retrying after WAIT is left to the caller.

Top module: `swd_host_engine`

## Requirements
- R1: The request goes out LSB first as eight bits: bit0 start = 1, bit1 `sel_ap`, bit2 `is_read`, bit3 `addr[0]`, bit4 `addr[1]`, bit5 parity, bit6 stop = 0, bit7 park = 1, with the host driving the line (`swdio_oe` = 1).
- R2: The parity bit is chosen so that `sel_ap`, `is_read`, `addr[1:0]` and the parity bit together contain an even number of ones.
- R3: After the request the host releases the line (`swdio_oe` = 0) for one turnaround period and then samples three acknowledge bits, the first of which is ack bit 0. The host never drives the line while it samples.
- R4: The acknowledge is decoded as OK = 3'b001, WAIT = 3'b010 and FAULT = 3'b100. Any other pattern is a protocol error. `status` encodes these as OK = 0, WAIT = 1, FAULT = 2 and protocol error = 3.
- R5: On WAIT, FAULT or protocol error the data phase is skipped. One turnaround period follows, and then `done` carries the decoded status.
- R6: On an OK read, 32 data bits (LSB first) and one parity bit are sampled directly after the acknowledge, followed by one turnaround. The word appears on `rdata`. If the data does not have even parity, the status is protocol error.
- R7: On an OK write, one turnaround comes after the acknowledge. The host then drives `wdata` LSB first followed by an even-parity bit.
- R8: For a debug-port write to address 3 (target select), the acknowledge is ignored, the write data is always sent and the status is OK.
- R9: After an access-port transfer with status OK, the engine inserts `idle_cycles` clock periods with the line driven low. It adds none after debug-port transfers or after a non-OK status.
- R10: `swclk` is low while idle. Each bit lasts 2×`HALF_DIV` system clocks, low half first. The host changes `swdio_out`/`swdio_oe` only while `swclk` is low, and it samples `swdio_in` as `swclk` rises.
- R11: `busy` is high from acceptance until completion. `done` is a single-cycle pulse that coincides with `busy` falling. A `start` received while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (accepted when idle) |
| sel_ap | input | 1 | 1 = access port, 0 = debug port |
| is_read | input | 1 | 1 = read, 0 = write |
| addr | input | 2 | Register address bits A[3:2] |
| wdata | input | 32 | Write data |
| idle_cycles | input | IDLE_W | Idle periods after an OK access-port transfer |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Completion status (R4 encoding) |
| rdata | output | 32 | Read data |
| swclk | output | 1 | Generated debug clock |
| swdio_out | output | 1 | Data line value driven by the host |
| swdio_oe | output | 1 | Host drive enable for the data line |
| swdio_in | input | 1 | Data line value seen from the target |

## Verification
The target-select exception (R8) and the acknowledge decision (R4/R5) are resolved on the same bit boundary. On that edge the engine picks between the write data path and the abort path. The bench provokes the overlap by answering a target-select write with an illegal acknowledge of 3'b111. It expects the full 33-bit write and status OK. It then sends a debug-port read to the same address with the same acknowledge and expects an abort with protocol error. A second overlap is a read parity error together with a non-zero idle count. Here the error must cancel the idle periods, and the bench judges this from the exact count of clock periods and from the line level in each one.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

  localparam int unsigned REQ_BITS  = 8;
  localparam int unsigned ACK_BITS  = 3;
  localparam int unsigned WORD_BITS = 32;

  typedef enum logic [1:0] {
    SW_OK    = 2'd0,
    SW_WAIT  = 2'd1,
    SW_FAULT = 2'd2,
    SW_PROTO = 2'd3
  } swd_status_e;

  typedef enum logic [2:0] {
    P_IDLE,
    P_REQ,
    P_TRN_A,
    P_ACK,
    P_RDATA,
    P_TRN_B,
    P_WDATA,
    P_TAIL
  } swd_phase_e;

  typedef struct packed {
    logic       ap;
    logic       rd;
    logic [1:0] addr;
  } swd_req_t;

  function automatic logic req_parity(swd_req_t r);
    return ^{r.ap, r.rd, r.addr};
  endfunction

  // wire order is bit 0 first
  function automatic logic [REQ_BITS-1:0] build_request(swd_req_t r);
    return {1'b1, 1'b0, req_parity(r), r.addr[1], r.addr[0], r.rd, r.ap, 1'b1};
  endfunction

  function automatic swd_status_e decode_ack(logic [ACK_BITS-1:0] a);
    case (a)
      3'b001:  return SW_OK;
      3'b010:  return SW_WAIT;
      3'b100:  return SW_FAULT;
      default: return SW_PROTO;
    endcase
  endfunction

  function automatic logic is_target_select(swd_req_t r);
    return !r.ap && !r.rd && (r.addr == 2'b11);
  endfunction

  function automatic logic word_parity(logic [WORD_BITS-1:0] w);
    return ^w;
  endfunction

endpackage

// File: rtl/swd_host_clkgen.sv
module swd_host_clkgen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic swclk,
  output logic rise_ev,
  output logic bit_end
);

  localparam int unsigned PERIOD = 2 * HALF_DIV;
  localparam int unsigned PH_W   = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [PH_W-1:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ph <= '0;
    else if (!run)                         ph <= '0;
    else if (ph == PH_W'(PERIOD - 1))      ph <= '0;
    else                                   ph <= ph + 1'b1;
  end

  // low half first, then high half
  assign swclk   = run && (ph >= PH_W'(HALF_DIV));
  assign rise_ev = run && (ph == PH_W'(HALF_DIV));
  assign bit_end = run && (ph == PH_W'(PERIOD - 1));

  // R10
  rise_precedes_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> swclk);

endmodule

// File: rtl/swd_host_seq.sv
module swd_host_seq
  import swd_host_pkg::*;
#(
  parameter int unsigned IDLE_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  swd_req_t                   req,
  input  logic [IDLE_W-1:0]          idle_cycles,
  input  logic                       bit_end,
  input  logic [ACK_BITS-1:0]        ack_bits,
  input  logic                       rpar_ok,
  output swd_phase_e                 phase,
  output logic [CNT_W-1:0]           cnt,
  output logic                       busy,
  output logic                       done,
  output swd_status_e                status
);

  swd_req_t          req_q;
  logic [IDLE_W-1:0] idle_q;
  logic              wr_pending;
  logic              tsel_q;
  logic              want_tail;
  swd_status_e       ack_status;

  assign tsel_q     = is_target_select(req_q);
  assign ack_status = decode_ack(ack_bits);
  assign want_tail  = req_q.ap && (status == SW_OK) && (idle_q != '0);
  assign busy       = (phase != P_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= P_IDLE;
      cnt        <= '0;
      done       <= 1'b0;
      status     <= SW_OK;
      req_q      <= '0;
      idle_q     <= '0;
      wr_pending <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == P_IDLE) begin
        if (start) begin
          phase      <= P_REQ;
          cnt        <= '0;
          req_q      <= req;
          idle_q     <= idle_cycles;
          status     <= SW_OK;
          wr_pending <= 1'b0;
        end
      end else if (bit_end) begin
        cnt <= cnt + 1'b1;
        case (phase)
          P_REQ: begin
            if (cnt == CNT_W'(REQ_BITS - 1)) begin
              phase <= P_TRN_A;
              cnt   <= '0;
            end
          end
          P_TRN_A: begin
            phase <= P_ACK;
            cnt   <= '0;
          end
          P_ACK: begin
            if (cnt == CNT_W'(ACK_BITS - 1)) begin
              cnt <= '0;
              if (tsel_q) begin
                status     <= SW_OK;
                phase      <= P_TRN_B;
                wr_pending <= 1'b1;
              end else begin
                status <= ack_status;
                if (ack_status == SW_OK && req_q.rd) begin
                  phase <= P_RDATA;
                end else begin
                  phase      <= P_TRN_B;
                  wr_pending <= (ack_status == SW_OK);
                end
              end
            end
          end
          P_RDATA: begin
            if (cnt == CNT_W'(WORD_BITS)) begin
              cnt   <= '0;
              phase <= P_TRN_B;
              if (!rpar_ok) status <= SW_PROTO;
            end
          end
          P_TRN_B: begin
            cnt <= '0;
            if (wr_pending) begin
              phase      <= P_WDATA;
              wr_pending <= 1'b0;
            end else if (want_tail) begin
              phase <= P_TAIL;
            end else begin
              phase <= P_IDLE;
              done  <= 1'b1;
            end
          end
          P_WDATA: begin
            if (cnt == CNT_W'(WORD_BITS)) begin
              cnt <= '0;
              if (want_tail) begin
                phase <= P_TAIL;
              end else begin
                phase <= P_IDLE;
                done  <= 1'b1;
              end
            end
          end
          P_TAIL: begin
            if (cnt == CNT_W'(idle_q) - 1'b1) begin
              cnt   <= '0;
              phase <= P_IDLE;
              done  <= 1'b1;
            end
          end
          default: begin
            phase <= P_IDLE;
          end
        endcase
      end
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  data_only_after_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_RDATA || phase == P_WDATA) |-> (status == SW_OK));

  // R7
  wdata_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_WDATA) |-> !req_q.rd);

  // R9
  tail_only_after_ap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_TAIL) |-> (req_q.ap && status == SW_OK));

endmodule

// File: rtl/swd_host_dpath.sv
module swd_host_dpath
  import swd_host_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  swd_req_t              req,
  input  logic [WORD_BITS-1:0]  wdata,
  input  swd_phase_e            phase,
  input  logic [CNT_W-1:0]      cnt,
  input  logic                  rise_ev,
  input  logic                  swdio_in,
  output logic                  swdio_out,
  output logic                  swdio_oe,
  output logic [ACK_BITS-1:0]   ack_bits,
  output logic [WORD_BITS-1:0]  rdata,
  output logic                  rpar_ok
);

  logic [REQ_BITS-1:0]  req_bits_q;
  logic [WORD_BITS-1:0] wdata_q;
  logic                 rpar_q;
  logic                 last_word_bit;

  assign last_word_bit = (cnt == CNT_W'(WORD_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_bits_q <= '0;
      wdata_q    <= '0;
      ack_bits   <= '0;
      rdata      <= '0;
      rpar_q     <= 1'b0;
    end else if (load) begin
      req_bits_q <= build_request(req);
      wdata_q    <= wdata;
      ack_bits   <= '0;
    end else if (rise_ev) begin
      if (phase == P_ACK) begin
        ack_bits[cnt[1:0]] <= swdio_in;
      end else if (phase == P_RDATA) begin
        if (last_word_bit) rpar_q            <= swdio_in;
        else               rdata[cnt[4:0]]   <= swdio_in;
      end
    end
  end

  assign rpar_ok = (word_parity(rdata) == rpar_q);

  always_comb begin
    swdio_out = 1'b0;
    swdio_oe  = 1'b0;
    case (phase)
      P_REQ: begin
        swdio_out = req_bits_q[cnt[2:0]];
        swdio_oe  = 1'b1;
      end
      P_WDATA: begin
        swdio_out = last_word_bit ? word_parity(wdata_q) : wdata_q[cnt[4:0]];
        swdio_oe  = 1'b1;
      end
      P_TAIL: begin
        swdio_out = 1'b0;
        swdio_oe  = 1'b1;
      end
      default: begin
        swdio_out = 1'b0;
        swdio_oe  = 1'b0;
      end
    endcase
  end

  // R1
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != P_IDLE) |=> $stable(req_bits_q));

  // R7
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != P_IDLE) |=> $stable(wdata_q));

endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
  import swd_host_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned IDLE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sel_ap,
  input  logic              is_read,
  input  logic [1:0]        addr,
  input  logic [31:0]       wdata,
  input  logic [IDLE_W-1:0] idle_cycles,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [31:0]       rdata,
  output logic              swclk,
  output logic              swdio_out,
  output logic              swdio_oe,
  input  logic              swdio_in
);

  localparam int unsigned CNT_W = (IDLE_W > 6) ? IDLE_W : 6;

  swd_req_t            req_in;
  swd_phase_e          phase;
  swd_status_e         status_e;
  logic [CNT_W-1:0]    cnt;
  logic                rise_ev;
  logic                bit_end;
  logic [ACK_BITS-1:0] ack_bits;
  logic                rpar_ok;
  logic                load;
  logic                target_sample;

  assign req_in        = '{ap: sel_ap, rd: is_read, addr: addr};
  assign load          = start && (phase == P_IDLE);
  assign target_sample = rise_ev && (phase == P_ACK || phase == P_RDATA);
  assign status        = status_e;

  swd_host_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .swclk   (swclk),
    .rise_ev (rise_ev),
    .bit_end (bit_end)
  );

  swd_host_seq #(.IDLE_W(IDLE_W), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .req         (req_in),
    .idle_cycles (idle_cycles),
    .bit_end     (bit_end),
    .ack_bits    (ack_bits),
    .rpar_ok     (rpar_ok),
    .phase       (phase),
    .cnt         (cnt),
    .busy        (busy),
    .done        (done),
    .status      (status_e)
  );

  swd_host_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .req       (req_in),
    .wdata     (wdata),
    .phase     (phase),
    .cnt       (cnt),
    .rise_ev   (rise_ev),
    .swdio_in  (swdio_in),
    .swdio_out (swdio_out),
    .swdio_oe  (swdio_oe),
    .ack_bits  (ack_bits),
    .rdata     (rdata),
    .rpar_ok   (rpar_ok)
  );

  // R10
  clk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !swclk);

  // R10
  drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swclk && $past(swclk)) |-> ($stable(swdio_out) && $stable(swdio_oe)));

  // R3
  released_when_sampling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    target_sample |-> !swdio_oe);

  // R11
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

// File: tb/swd_host_engine_bench.sv
`timescale 1ns/1ps
module swd_host_engine_bench;

  localparam int HD = 3;
  localparam int IW = 8;
  localparam int MAXB = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          sel_ap = 1'b0;
  logic          is_read = 1'b0;
  logic [1:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [IW-1:0] idle_cycles = '0;
  logic          busy, done, swclk, swdio_out, swdio_oe;
  logic          swdio_in = 1'b0;
  logic [1:0]    status;
  logic [31:0]   rdata;

  always #4 clk = ~clk;

  swd_host_engine #(.HALF_DIV(HD), .IDLE_W(IW)) u_swd_host_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_ap(sel_ap), .is_read(is_read),
    .addr(addr), .wdata(wdata), .idle_cycles(idle_cycles), .busy(busy), .done(done),
    .status(status), .rdata(rdata), .swclk(swclk), .swdio_out(swdio_out),
    .swdio_oe(swdio_oe), .swdio_in(swdio_in)
  );

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  finished = 0;

  logic exp_oe [0:MAXB-1];
  logic exp_out[0:MAXB-1];
  logic resp   [0:MAXB-1];
  int   bit_base = 0;
  int   bitk = 0;
  int   wave_bad = 0;
  int   period_bad = 0;
  realtime prev_rise = 0;

  // target-side monitor: compare host drive at each rising edge
  always @(posedge swclk) begin
    int idx;
    idx = bitk - bit_base;
    if (idx >= 0 && idx < MAXB) begin
      if (swdio_oe !== exp_oe[idx] || (exp_oe[idx] && swdio_out !== exp_out[idx]))
        wave_bad++;
      if (idx > 0 && ($realtime - prev_rise) != real'(2 * HD * 8))
        period_bad++;
    end
    prev_rise = $realtime;
    bitk++;
  end

  // target drives its next bit while the clock is low
  always @(negedge swclk) begin
    int idx;
    idx = bitk - bit_base;
    if (idx >= 0 && idx < MAXB) swdio_in = resp[idx];
  end

  task automatic check(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic run_txn(input bit ap, input bit rd, input logic [1:0] a,
                         input logic [31:0] wd, input int idle,
                         input logic [2:0] ack, input logic [31:0] td,
                         input bit flip_par, input bit poke, input string rq);
    int   n;
    bit   tsel, okpath, par;
    logic [1:0] exp_st;
    int   wb0, pb0, guard;
    for (int i = 0; i < MAXB; i++) begin
      exp_oe[i] = 1'b0; exp_out[i] = 1'b0; resp[i] = 1'b0;
    end
    par  = ($countones({ap, rd, a}) % 2) == 1;
    tsel = (!ap && !rd && a == 2'd3);
    n = 0;
    // request, drive order start, ap, rd, A2, A3, parity, stop, park
    exp_oe[0] = 1; exp_out[0] = 1;
    exp_oe[1] = 1; exp_out[1] = ap;
    exp_oe[2] = 1; exp_out[2] = rd;
    exp_oe[3] = 1; exp_out[3] = a[0];
    exp_oe[4] = 1; exp_out[4] = a[1];
    exp_oe[5] = 1; exp_out[5] = par;
    exp_oe[6] = 1; exp_out[6] = 0;
    exp_oe[7] = 1; exp_out[7] = 1;
    n = 9;                                    // bit 8 is turnaround
    for (int i = 0; i < 3; i++) begin resp[n] = ack[i]; n++; end
    if (tsel || ack == 3'b001) exp_st = 2'd0;
    else if (ack == 3'b010)    exp_st = 2'd1;
    else if (ack == 3'b100)    exp_st = 2'd2;
    else                       exp_st = 2'd3;
    okpath = tsel || ack == 3'b001;
    if (!okpath) begin
      n++;                                    // turnaround only
    end else if (rd) begin
      for (int i = 0; i < 32; i++) begin resp[n] = td[i]; n++; end
      resp[n] = (^td) ^ flip_par; n++;
      if (flip_par) exp_st = 2'd3;
      n++;
    end else begin
      n++;
      for (int i = 0; i < 32; i++) begin exp_oe[n] = 1; exp_out[n] = wd[i]; n++; end
      exp_oe[n] = 1; exp_out[n] = ^wd; n++;
    end
    if (ap && exp_st == 2'd0) begin
      for (int i = 0; i < idle; i++) begin exp_oe[n] = 1; exp_out[n] = 0; n++; end
    end

    @(negedge clk);
    bit_base = bitk; wb0 = wave_bad; pb0 = period_bad;
    sel_ap = ap; is_read = rd; addr = a; wdata = wd; idle_cycles = IW'(idle);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, {rq, " busy after start"}, busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      sel_ap = ~ap; is_read = ~rd; addr = ~a; wdata = ~wd; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (done !== 1'b1 && guard < 5000) begin @(negedge clk); guard++; end
    check(done === 1'b1 && busy === 1'b0, {rq, " done with busy low"}, {busy, done}, 2'b01);
    check(status === exp_st, {rq, " status"}, status, exp_st);
    if (rd && exp_st == 2'd0)
      check(rdata === td, {rq, " read data"}, rdata, td);
    check((bitk - bit_base) == n, {rq, " clock period count"}, bitk - bit_base, n);
    check(wave_bad == wb0, {rq, " line waveform"}, wave_bad - wb0, 0);
    check(period_bad == pb0, {rq, " clock period length"}, period_bad - pb0, 0);
    @(negedge clk);
    check(done === 1'b0 && swclk === 1'b0, {rq, " done single pulse, clock parked"},
          {done, swclk}, 0);
  endtask

  task automatic t_reset;
    check(busy === 0 && done === 0 && swclk === 0 && swdio_oe === 0,
          "R10/R11 reset state", {busy, done, swclk, swdio_oe}, 0);
  endtask

  task automatic t_dp_read;
    run_txn(0, 1, 2'd0, 32'h0, 0, 3'b001, 32'h2BA0_1477, 0, 0, "R1/R2/R3/R6 dp read");
    run_txn(0, 1, 2'd1, 32'h0, 4, 3'b001, 32'h8000_0001, 0, 0, "R2/R9 dp read no idle");
  endtask

  task automatic t_ap_write_idle;
    run_txn(1, 0, 2'd1, 32'hA5C3_0F17, 4, 3'b001, 32'h0, 0, 0, "R7/R9 ap write idle");
    run_txn(0, 0, 2'd2, 32'h1234_5678, 5, 3'b001, 32'h0, 0, 0, "R7/R9 dp write no idle");
  endtask

  task automatic t_ap_read_idle;
    run_txn(1, 1, 2'd3, 32'h0, 2, 3'b001, 32'hDEAD_BEEF, 0, 0, "R6/R9 ap read idle");
  endtask

  task automatic t_ack_errors;
    run_txn(1, 1, 2'd0, 32'h0, 3, 3'b010, 32'hFFFF_FFFF, 0, 0, "R4/R5 wait");
    run_txn(1, 0, 2'd2, 32'h5555_AAAA, 3, 3'b100, 32'h0, 0, 0, "R4/R5 fault");
    run_txn(0, 1, 2'd1, 32'h0, 0, 3'b111, 32'h0, 0, 0, "R4/R5 bad ack ones");
    run_txn(1, 0, 2'd0, 32'h1, 2, 3'b000, 32'h0, 0, 0, "R4/R5 no answer");
  endtask

  task automatic t_target_select;
    run_txn(0, 0, 2'd3, 32'h0100_2927, 0, 3'b111, 32'h0, 0, 0, "R8 target select ack ignored");
    run_txn(0, 1, 2'd3, 32'h0, 0, 3'b111, 32'h0, 0, 0, "R8 read same address checks ack");
  endtask

  task automatic t_read_parity;
    run_txn(1, 1, 2'd2, 32'h0, 3, 3'b001, 32'h0F0F_0001, 1, 0, "R6/R9 read parity error");
  endtask

  task automatic t_busy_ignore;
    run_txn(1, 0, 2'd0, 32'hC001_D00D, 1, 3'b001, 32'h0, 0, 1, "R11 start ignored while busy");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_dp_read();
    t_ap_write_idle();
    t_ap_read_idle();
    t_ack_errors();
    t_target_select();
    t_read_parity();
    t_busy_ignore();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R11 watchdog: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule